// File: doc/BRIEF.md
# Transport Stream PID Filter

This block takes a byte-wide MPEG transport stream, one byte per cycle whenever `in_valid` is high. It finds the 188-byte packet grid by looking for the 0x47 sync byte. It reads the 13-bit PID from each packet header and compares it with a 64-entry table in which every entry can be enabled on its own. Packets whose PID matches go out on a ready/valid byte port, with start-of-packet and end-of-packet marks.

The input can never be stalled. Each packet is staged in an internal byte buffer and becomes visible at the output only after its last byte has arrived. The buffer space is checked at the sync byte. If that space cannot hold a full packet, the whole packet is discarded and a saturating drop counter increments. A second saturating counter records each loss of sync lock.

Top module: `ts_pid_filter`

## Requirements
- R1: After reset, `out_valid`, `locked`, `drop_count` and `sync_loss_count` are all 0, and every table entry is disabled.
- R2: `locked` rises after a 0x47 byte that is the third in a row at 188-byte spacing. A candidate sync that is not followed by 0x47 exactly 188 bytes later is abandoned, and hunting restarts. The packet that begins at the locking sync byte is the first one eligible for forwarding.
- R3: While locked, a packet whose first byte is not 0x47 is discarded and lock is kept. A second such packet in a row clears `locked` and increments `sync_loss_count`. A correct sync between the two misses resets the miss count.
- R4: The PID is {bits 4..0 of packet byte 1, packet byte 2}. Bits 7..5 of byte 1 are ignored. A packet is forwarded only if some table entry holds that PID with its enable bit set. A write with `cfg_we` high loads entry `cfg_index` (0..63) with `cfg_pid` and `cfg_enable`.
- R5: PID 0x1FFF is never forwarded, even when an enabled entry holds it.
- R6: A forwarded packet appears on the output as all 188 bytes, in arrival order. `out_sop` is set on byte 0 and `out_eop` on byte 187. A packet is never cut short.
- R7: A matching packet is forwarded only if at least 188 bytes of buffer are free at its sync byte. Otherwise the whole packet is dropped and `drop_count` increments. A non-matching packet never changes `drop_count`.
- R8: Both counters saturate at their all-ones value.
- R9: While `out_valid` is high and `out_ready` is low, `out_data`, `out_sop` and `out_eop` hold their values. The input is accepted in every cycle, whatever the output does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Input stream byte |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_index | input | $clog2(N_PID) | Table entry to write |
| cfg_pid | input | 13 | PID value to store |
| cfg_enable | input | 1 | Enable bit to store |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | Byte 0 of a packet |
| out_eop | output | 1 | Last byte of a packet |
| locked | output | 1 | Sync lock held |
| drop_count | output | CNT_W | Saturating count of matching packets dropped for lack of space |
| sync_loss_count | output | CNT_W | Saturating count of lock losses |

## Verification
The bench feeds a stray 0x47 ahead of the real grid. A filter that locked on any three sync bytes, or that did not restart after a failed spacing check, would then lock one packet too early. It sets bits 7..5 of byte 1 and programs entries 0 and 63 to catch PID extraction and table coverage errors. It also includes a disabled entry and an enabled 0x1FFF entry, which a loose matcher would forward. With the output stalled, the third and fourth back-to-back matches must be dropped whole while a non-matching packet leaves the count alone. A design that checked space late, counted filtered packets or let a partial packet through would emit stray bytes or a wrong count. A later round pushes the narrow counter past its limit. Single and double sync misses separate keeping lock from losing it, and the bench then checks that three fresh syncs are needed to lock again.

// File: rtl/ts_pid_filter.sv
module ts_pid_filter #(
  parameter int          N_PID       = 64,
  parameter int          PKT_LEN     = 188,
  parameter int          BUF_DEPTH   = 512,
  parameter int          CNT_W       = 16,
  parameter int          LOCK_HITS   = 3,
  parameter int          LOSS_MISSES = 2,
  parameter logic [7:0]  SYNC_BYTE   = 8'h47,
  parameter logic [12:0] NULL_PID    = 13'h1FFF,
  localparam int IDX_W = $clog2(N_PID)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_index,
  input  logic [12:0]      cfg_pid,
  input  logic             cfg_enable,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic             locked,
  output logic [CNT_W-1:0] drop_count,
  output logic [CNT_W-1:0] sync_loss_count
);
  localparam int AW     = $clog2(BUF_DEPTH);
  localparam int POS_W  = $clog2(PKT_LEN);
  localparam int HIT_W  = $clog2(LOCK_HITS + 1);
  localparam int MISS_W = $clog2(LOSS_MISSES + 1);
  localparam logic [AW:0]    ROOM_LIM = (AW+1)'(BUF_DEPTH - PKT_LEN);
  localparam logic [AW:0]    DEPTH_V  = (AW+1)'(BUF_DEPTH);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(PKT_LEN - 1);

  typedef enum logic [1:0] {HUNT, VERIFY, LOCK} sync_st_t;

  sync_st_t          st;
  logic [POS_W-1:0]  pos, rpos;
  logic [HIT_W-1:0]  hits;
  logic [MISS_W-1:0] misses;
  logic [12:0]       tab_pid [N_PID];
  logic [N_PID-1:0]  tab_en;
  logic [7:0]        mem [BUF_DEPTH];
  logic [AW:0]       wcom, wspec, rptr;
  logic              cap, short_room, hit;
  logic [4:0]        pid_hi;

  wire              is_sync   = in_byte == SYNC_BYTE;
  wire              at_head   = (st != HUNT) && (pos == '0);
  wire              last_byte = pos == LAST_POS;
  wire [POS_W-1:0]  pos_nxt   = last_byte ? '0 : pos + POS_W'(1);
  wire [AW:0]       used      = wcom - rptr;
  wire              room      = used <= ROOM_LIM;
  wire              start_pkt = in_valid && at_head && is_sync &&
                                (st == LOCK || hits == HIT_W'(LOCK_HITS - 1));
  wire              wen       = in_valid && (cap || (start_pkt && room));
  wire [12:0]       pid_now   = {pid_hi, in_byte};
  wire              pid_byte  = in_valid && (st != HUNT) && (pos == POS_W'(2));
  wire              pop       = out_valid && out_ready;

  assign locked    = st == LOCK;
  assign out_valid = rptr != wcom;
  assign out_data  = mem[rptr[AW-1:0]];
  assign out_sop   = rpos == '0;
  assign out_eop   = rpos == LAST_POS;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < N_PID; i++)
      if (tab_en[i] && tab_pid[i] == pid_now) hit = 1'b1;
    if (pid_now == NULL_PID) hit = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tab_en <= '0;
    else if (cfg_we) tab_en[cfg_index] <= cfg_enable;

  always_ff @(posedge clk)
    if (cfg_we) tab_pid[cfg_index] <= cfg_pid;

  always_ff @(posedge clk)
    if (wen) mem[wspec[AW-1:0]] <= in_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= HUNT; pos <= '0; hits <= '0; misses <= '0; pid_hi <= '0;
      wcom <= '0; wspec <= '0; rptr <= '0; rpos <= '0;
      cap <= 1'b0; short_room <= 1'b0;
      drop_count <= '0; sync_loss_count <= '0;
    end else begin
      if (pop) begin
        rptr <= rptr + (AW+1)'(1);
        rpos <= out_eop ? '0 : rpos + POS_W'(1);
      end
      if (in_valid) begin
        case (st)
          HUNT: if (is_sync) begin
            st <= VERIFY; hits <= HIT_W'(1); pos <= POS_W'(1);
          end
          VERIFY: begin
            pos <= pos_nxt;
            if (pos == '0) begin
              if (!is_sync) begin
                st <= HUNT; pos <= '0;
              end else if (hits == HIT_W'(LOCK_HITS - 1)) begin
                st <= LOCK; misses <= '0;
              end else hits <= hits + HIT_W'(1);
            end
          end
          LOCK: begin
            pos <= pos_nxt;
            if (pos == '0) begin
              if (is_sync) misses <= '0;
              else if (misses == MISS_W'(LOSS_MISSES - 1)) begin
                st <= HUNT; pos <= '0;
                if (sync_loss_count != '1) sync_loss_count <= sync_loss_count + CNT_W'(1);
              end else misses <= misses + MISS_W'(1);
            end
          end
          default: st <= HUNT;
        endcase
        if (st != HUNT && pos == POS_W'(1)) pid_hi <= in_byte[4:0];
        if (start_pkt) begin
          cap        <= room;
          short_room <= !room;
        end
        if (wen) wspec <= wspec + (AW+1)'(1);
        if (pid_byte) begin
          short_room <= 1'b0;
          if (cap && !hit) begin
            cap   <= 1'b0;
            wspec <= wcom;
          end
          if (short_room && hit && drop_count != '1) drop_count <= drop_count + CNT_W'(1);
        end
        if (cap && last_byte) begin
          cap  <= 1'b0;
          wcom <= wspec + (AW+1)'(1);
        end
      end
    end
  end

  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wspec - rptr) <= DEPTH_V);

  // R7
  drop_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_count >= $past(drop_count));

  // R3
  loss_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> (sync_loss_count != $past(sync_loss_count)) || (&sync_loss_count));

  // R2
  lock_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(in_valid && in_byte == SYNC_BYTE));
endmodule

// File: tb/ts_pid_filter_bench.sv
module ts_pid_filter_bench;
  localparam int PL = 188;
  localparam int CW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, in_valid, cfg_we, cfg_enable, out_ready;
  logic [7:0]    in_byte, out_data;
  logic [5:0]    cfg_index;
  logic [12:0]   cfg_pid;
  logic          out_valid, out_sop, out_eop, locked;
  logic [CW-1:0] drop_count, sync_loss_count;

  ts_pid_filter #(.CNT_W(CW)) u_ts_pid_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .cfg_we(cfg_we), .cfg_index(cfg_index), .cfg_pid(cfg_pid), .cfg_enable(cfg_enable),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .locked(locked),
    .drop_count(drop_count), .sync_loss_count(sync_loss_count));

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0, bp_mode = 0, ready_lvl = 1;
  logic [9:0] expq[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    #2;
    out_ready = bp_mode ? (cyc % 3 != 0) : ready_lvl;
  end

  always @(negedge clk)
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) check(0, "R6 unexpected byte", {out_eop, out_sop, out_data}, 0);
      else begin
        logic [9:0] e;
        e = expq.pop_front();
        check({out_eop, out_sop, out_data} == e, "R6 byte/sop/eop", {out_eop, out_sop, out_data}, e);
      end
    end

  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1; in_byte = b;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_pkt(input logic [12:0] pid, input int seq, input bit good,
                          input bit fwd, input logic [2:0] flags);
    for (int k = 0; k < PL; k++) begin
      logic [7:0] b;
      if (k == 0) b = good ? 8'h47 : 8'h00;
      else if (k == 1) b = {flags, pid[12:8]};
      else if (k == 2) b = pid[7:0];
      else begin
        b = 8'((seq * 7 + k) & 255);
        if (b == 8'h47) b = 8'h48;
      end
      if (fwd) expq.push_back({k == PL-1, k == 0, b});
      send_byte(b);
    end
  endtask

  task automatic program_entry(input int idx, input logic [12:0] pid, input bit en);
    cfg_we = 1'b1; cfg_index = 6'(idx); cfg_pid = pid; cfg_enable = en;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic drain(input string req);
    for (int n = 0; n < 3000 && expq.size() != 0; n++) begin
      @(posedge clk); #1;
    end
    repeat (4) @(posedge clk);
    #1;
    check(expq.size() == 0 && !out_valid, req, expq.size(), 0);
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_byte = 0; cfg_we = 0; cfg_index = 0; cfg_pid = 0; cfg_enable = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1
    check(!out_valid, "R1 out_valid", out_valid, 0);
    check(!locked, "R1 locked", locked, 0);
    check(drop_count == 0 && sync_loss_count == 0, "R1 counters", {drop_count, sync_loss_count}, 0);

    program_entry(0, 13'h100, 1);
    program_entry(63, 13'h0ABC, 1);
    program_entry(1, 13'h1FFF, 1);
    program_entry(5, 13'h200, 0);

    // R2: stray sync, failed spacing, then lock on third real sync
    send_byte(8'h47);
    for (int i = 0; i < 20; i++) send_byte(8'h11);
    send_pkt(13'h100, 1, 1, 0, 3'b000);
    send_pkt(13'h100, 2, 1, 0, 3'b000);
    send_pkt(13'h100, 3, 1, 0, 3'b000);
    check(!locked, "R2 no early lock", locked, 0);
    send_pkt(13'h100, 4, 1, 1, 3'b000);
    check(locked, "R2 lock after third sync", locked, 1);

    // R4, R5: table matching
    send_pkt(13'h0ABC, 5, 1, 1, 3'b111);
    send_pkt(13'h200, 6, 1, 0, 3'b000);
    send_pkt(13'h1FFF, 7, 1, 0, 3'b000);
    send_pkt(13'h555, 8, 1, 0, 3'b000);
    send_pkt(13'h000, 9, 1, 0, 3'b001);
    drain("R4 R5 filtered stream");
    program_entry(5, 13'h200, 1);
    send_pkt(13'h200, 10, 1, 1, 3'b010);
    drain("R4 enabled entry");
    check(drop_count == 0, "R7 no drops for filtered", drop_count, 0);

    // R9: toggling ready
    bp_mode = 1;
    send_pkt(13'h100, 11, 1, 1, 3'b000);
    send_pkt(13'h0ABC, 12, 1, 1, 3'b000);
    drain("R9 backpressure order");
    bp_mode = 0;

    // R7: stalled output, whole-packet drops
    ready_lvl = 0;
    @(posedge clk); #1;
    send_pkt(13'h100, 13, 1, 1, 3'b000);
    send_pkt(13'h100, 14, 1, 1, 3'b000);
    send_pkt(13'h100, 15, 1, 0, 3'b000);
    send_pkt(13'h0ABC, 16, 1, 0, 3'b000);
    send_pkt(13'h555, 17, 1, 0, 3'b000);
    check(drop_count == 2, "R7 drop count", drop_count, 2);
    check(out_valid && out_sop, "R9 held head byte", {out_valid, out_sop}, 3);
    ready_lvl = 1;
    drain("R7 only fitting packets");

    // R8: saturation
    ready_lvl = 0;
    @(posedge clk); #1;
    send_pkt(13'h100, 18, 1, 1, 3'b000);
    send_pkt(13'h100, 19, 1, 1, 3'b000);
    send_pkt(13'h100, 20, 1, 0, 3'b000);
    send_pkt(13'h100, 21, 1, 0, 3'b000);
    check(drop_count == 3, "R8 drop saturation", drop_count, 3);
    ready_lvl = 1;
    drain("R8 drain");

    // R3: sync misses
    send_pkt(13'h100, 22, 0, 0, 3'b000);
    check(locked, "R3 single miss keeps lock", locked, 1);
    send_pkt(13'h100, 23, 1, 1, 3'b000);
    send_pkt(13'h100, 24, 0, 0, 3'b000);
    check(locked && sync_loss_count == 0, "R3 miss count reset", {locked, sync_loss_count}, 4);
    send_pkt(13'h100, 25, 0, 0, 3'b000);
    check(!locked, "R3 lock lost", locked, 0);
    check(sync_loss_count == 1, "R3 loss count", sync_loss_count, 1);
    send_pkt(13'h100, 26, 1, 0, 3'b000);
    send_pkt(13'h100, 27, 1, 0, 3'b000);
    check(!locked, "R2 relock needs three", locked, 0);
    send_pkt(13'h100, 28, 1, 1, 3'b000);
    check(locked, "R2 relock", locked, 1);
    drain("R6 final drain");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule